// File: doc/BRIEF.md
# Multi-Master Doorbell Register Unit

This block is a bank of doorbells. Up to 32 bus masters use them to signal each other. Every doorbell has four 32-bit registers in a 256-byte window, and each register has one bit per master ID:

- a trigger register, which a master writes to ring the doorbell;
- an enable mask, chosen by the doorbell's owner;
- a raw record of every master that has rung it;
- a pending record of the rings that the enable mask let through.

The master ID arrives on a sideband input with each bus write. The doorbell interrupt is high while any of that doorbell's pending bits is set.

The doorbell windows sit after the space taken by the other sub-units of the larger block. The first window starts at (1 + mailboxes/2 + shared semaphores + arbitrated semaphores) × 64 KiB, and each further window is 0x100 bytes higher. A read-only dimensioning word at 0x380 gives the count of each sub-unit. Every count is a parameter.

The bus port takes one access per cycle. Writes take effect at the clock edge. Read data is registered, so it appears one cycle after the address is presented.

Top module: `dbell_unit`

## Requirements
- R1: After a synchronous reset, every enable, raw and pending register reads zero, all interrupt outputs are low, and read data is zero.
- R2: Window offset 0x4 is the enable mask. It is read/write, and all 32 bits read back as written.
- R3: A write to window offset 0x0 with data bit 0 equal to 1 sets raw bit [ID] for the master ID on the sideband input. This happens whatever the enable mask holds. Raw is read at offset 0x8.
- R4: That same ring sets pending bit [ID] (read at offset 0xC) only when enable bit [ID] is 1. A ring from a disabled master leaves pending unchanged.
- R5: Writing a value to pending clears exactly the bits that are 1 in the value and leaves the other bits unchanged.
- R6: Raw is cleared the same way: each 1 in the written value clears that bit.
- R7: Interrupt output bit d is the OR of doorbell d's pending bits. It changes at the same clock edge as the pending register.
- R8: Pending bits and the interrupt stay set after their enable bits are cleared, until the pending bits themselves are cleared.
- R9: Address 0x380 reads the dimensioning word. Bits [3:0] hold the mailbox count, [7:4] the shared semaphore count, [11:8] the arbitrated semaphore count, [15:12] the doorbell count and [19:16] the shared interrupt count. The upper bits are zero.
- R10: Doorbell d's window begins at (1 + N_MBOX/2 + N_SSEM + N_ASEM) × 0x10000 + d × 0x100. An access to one window never changes another doorbell.
- R11: Reads of unmapped addresses, and reads of the trigger offset, return zero.
- R12: Read data shows register contents as they were before the clock edge that captures the address. A read and a write to the same register in one cycle therefore return the old value.
- R13: A trigger write with data bit 0 equal to 0 changes neither raw nor pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_mid | input | MID_W | Master ID of the current write |
| bus_rdata | output | 32 | Registered read data |
| db_irq | output | N_DB | Per-doorbell interrupt |

## Verification
The single bus port allows only one register access per cycle, so the functions that can share a cycle are a read of a register and a write to that same register. The bench provokes this with a write-one-to-clear of a pending bit while the bus addresses that pending register. It then expects the old value on the next cycle and the cleared value on a later read. The interrupt is judged in the same sequence: it must drop at the same edge that clears the pending bit.

// File: rtl/dbell_pkg.sv
`timescale 1ns/1ps
package dbell_pkg;
  localparam int REG_W = 32;

  // Register selected by address bits [3:2] inside a doorbell window.
  typedef enum logic [1:0] {
    SEL_TRIG = 2'd0,
    SEL_EN   = 2'd1,
    SEL_RAW  = 2'd2,
    SEL_PEND = 2'd3
  } reg_sel_e;

  localparam int unsigned DIM_ADDR = 32'h380;

  function automatic int unsigned db_base(input int unsigned n_mbox,
                                          input int unsigned n_ssem,
                                          input int unsigned n_asem);
    return (1 + n_mbox / 2 + n_ssem + n_asem) << 16;
  endfunction
endpackage

// File: rtl/dbell_decode.sv
`timescale 1ns/1ps
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int N_DB    = 4,
  parameter int DB_BASE = 32'hD0000,
  parameter int IDX_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              dim_hit,
  output logic              db_hit,
  output logic [IDX_W-1:0]  idx,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(DB_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(N_DB * 256);
  localparam logic [ADDR_W-1:0] DIM_A  = ADDR_W'(DIM_ADDR);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off     = addr - BASE_A;
    dim_hit = (addr == DIM_A);
    db_hit  = (addr >= BASE_A) && (off < SPAN_A) &&
              (off[7:4] == 4'd0) && (off[1:0] == 2'd0);
    idx     = off[8 +: IDX_W];
    sel     = reg_sel_e'(off[3:2]);
  end
endmodule

// File: rtl/dbell_slot.sv
`timescale 1ns/1ps
module dbell_slot #(
  parameter int N_MASTER = 32,
  parameter int MID_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_trig,
  input  logic                wr_en,
  input  logic                wr_raw,
  input  logic                wr_pend,
  input  logic [31:0]         wdata,
  input  logic [MID_W-1:0]    mid,
  output logic [N_MASTER-1:0] en_q,
  output logic [N_MASTER-1:0] raw_q,
  output logic [N_MASTER-1:0] pend_q,
  output logic                irq_q
);
  logic [N_MASTER-1:0] ring_vec, raw_clr, pend_clr, raw_nxt, pend_nxt;

  always_comb begin
    ring_vec = (wr_trig && wdata[0]) ? (N_MASTER'(1) << mid) : '0;
    raw_clr  = wr_raw  ? wdata[N_MASTER-1:0] : '0;
    pend_clr = wr_pend ? wdata[N_MASTER-1:0] : '0;
    // a set arriving with a clear of the same bit wins
    raw_nxt  = (raw_q  & ~raw_clr)  | ring_vec;
    pend_nxt = (pend_q & ~pend_clr) | (ring_vec & en_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      raw_q  <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en) en_q <= wdata[N_MASTER-1:0];
      raw_q  <= raw_nxt;
      pend_q <= pend_nxt;
      irq_q  <= |pend_nxt;
    end
  end
endmodule

// File: rtl/dbell_unit.sv
`timescale 1ns/1ps
module dbell_unit
  import dbell_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int N_DB     = 4,
  parameter int N_MASTER = 32,
  parameter int N_MBOX   = 8,
  parameter int N_SSEM   = 4,
  parameter int N_ASEM   = 4,
  parameter int N_SINT   = 2,
  parameter int MID_W    = $clog2(N_MASTER)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic [MID_W-1:0]  bus_mid,
  output logic [31:0]       bus_rdata,
  output logic [N_DB-1:0]   db_irq
);
  localparam int IDX_W   = (N_DB > 1) ? $clog2(N_DB) : 1;
  localparam int DB_BASE = int'(db_base(N_MBOX, N_SSEM, N_ASEM));
  localparam logic [31:0] DIM_VAL = {12'd0, 4'(N_SINT), 4'(N_DB),
                                     4'(N_ASEM), 4'(N_SSEM), 4'(N_MBOX)};

  logic             dim_hit, db_hit;
  logic [IDX_W-1:0] idx;
  reg_sel_e         sel;

  logic [N_MASTER-1:0] en_a   [N_DB];
  logic [N_MASTER-1:0] raw_a  [N_DB];
  logic [N_MASTER-1:0] pend_a [N_DB];

  dbell_decode #(
    .ADDR_W(ADDR_W), .N_DB(N_DB), .DB_BASE(DB_BASE), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .dim_hit(dim_hit), .db_hit(db_hit), .idx(idx), .sel(sel)
  );

  for (genvar g = 0; g < N_DB; g++) begin : g_slot
    logic here;
    assign here = bus_we && db_hit && (idx == IDX_W'(g));
    dbell_slot #(.N_MASTER(N_MASTER), .MID_W(MID_W)) u_slot (
      .clk(clk), .rst(rst),
      .wr_trig(here && sel == SEL_TRIG),
      .wr_en  (here && sel == SEL_EN),
      .wr_raw (here && sel == SEL_RAW),
      .wr_pend(here && sel == SEL_PEND),
      .wdata(bus_wdata), .mid(bus_mid),
      .en_q(en_a[g]), .raw_q(raw_a[g]), .pend_q(pend_a[g]),
      .irq_q(db_irq[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (dim_hit) begin
      bus_rdata <= DIM_VAL;
    end else if (db_hit) begin
      case (sel)
        SEL_EN:   bus_rdata <= 32'(en_a[idx]);
        SEL_RAW:  bus_rdata <= 32'(raw_a[idx]);
        SEL_PEND: bus_rdata <= 32'(pend_a[idx]);
        default:  bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/dbell_chk.sv
`timescale 1ns/1ps
module dbell_chk #(
  parameter int ADDR_W = 24,
  parameter int N_DB   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic [N_DB-1:0]   db_irq
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (bus_rdata == 32'd0 && db_irq == '0));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(db_irq));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (db_irq != '0 && !$stable(db_irq)) |-> $past(bus_we));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(bus_addr) && $past(!bus_we) && !$past(rst)) |=> $stable(bus_rdata));
endmodule

bind dbell_unit dbell_chk #(.ADDR_W(ADDR_W), .N_DB(N_DB)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .db_irq(db_irq)
);

// File: tb/sim_dbell_unit.sv
`timescale 1ns/1ps
module sim_dbell_unit;
  localparam int AW = 24;
  localparam int ND = 4;
  localparam logic [AW-1:0] B0   = AW'((1 + 8/2 + 4 + 4) * 32'h10000);
  localparam logic [AW-1:0] O_EN = AW'(4), O_RAW = AW'(8), O_PND = AW'(12);

  logic          clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [4:0]    bus_mid = '0;
  logic [31:0]   bus_rdata;
  logic [ND-1:0] db_irq;
  int vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  dbell_unit u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_mid(bus_mid), .bus_rdata(bus_rdata),
    .db_irq(db_irq)
  );

  function automatic logic [AW-1:0] win(input int d, input logic [AW-1:0] o);
    return B0 + AW'(d * 256) + o;
  endfunction

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d,
                    input logic [4:0] m);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d; bus_mid = m;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq", 32'(db_irq), 32'd0);
    rd(win(0, O_EN), v);  check("R1 en", v, 0);
    rd(win(1, O_PND), v); check("R1 pend", v, 0);
    rd(win(3, O_RAW), v); check("R1 raw", v, 0);
    rd(AW'(32'h380), v);  check("R9 dim", v, 32'h0002_4448);
  endtask

  task automatic t_enable_rw;
    logic [31:0] v;
    wr(win(1, O_EN), 32'hA5A5_0003, 5'd0);
    rd(win(1, O_EN), v); check("R2 en readback", v, 32'hA5A5_0003);
    wr(win(3, O_EN), 32'h8000_0001, 5'd0);
    rd(win(3, O_EN), v); check("R10 db3 stride", v, 32'h8000_0001);
  endtask

  task automatic t_ring;
    logic [31:0] v;
    wr(win(0, O_EN), 32'h0000_0008, 5'd0);
    wr(win(0, 0), 32'd1, 5'd3);
    check("R7 irq on", 32'(db_irq), 32'b0001);
    rd(win(0, O_RAW), v); check("R3 raw", v, 32'h8);
    rd(win(0, O_PND), v); check("R4 pend", v, 32'h8);
    wr(win(0, 0), 32'd1, 5'd7);
    rd(win(0, O_RAW), v); check("R3 raw disabled", v, 32'h88);
    rd(win(0, O_PND), v); check("R4 pend gated", v, 32'h8);
    wr(win(0, 0), 32'd2, 5'd9);
    rd(win(0, O_RAW), v); check("R13 raw", v, 32'h88);
    rd(win(0, 0), v);     check("R11 trig reads 0", v, 0);
  endtask

  task automatic t_clear_same_cycle;
    logic [31:0] v;
    @(negedge clk);
    bus_addr = win(0, O_PND); bus_we = 1'b1; bus_wdata = 32'h8;
    @(negedge clk);
    bus_we = 1'b0;
    check("R7 irq drops with pend", 32'(db_irq), 32'd0);
    check("R12 old value", bus_rdata, 32'h8);
    @(negedge clk);
    check("R5 pend cleared", bus_rdata, 32'h0);
    wr(win(0, O_RAW), 32'h80, 5'd0);
    rd(win(0, O_RAW), v); check("R6 raw w1c", v, 32'h08);
  endtask

  task automatic t_isolation;
    logic [31:0] v;
    wr(win(2, O_EN), 32'h0000_0003, 5'd0);
    wr(win(2, 0), 32'd1, 5'd0);
    wr(win(2, 0), 32'd1, 5'd1);
    check("R10 only db2 irq", 32'(db_irq), 32'b0100);
    rd(win(3, O_PND), v); check("R10 db3 untouched", v, 0);
    wr(win(2, O_PND), 32'h1, 5'd0);
    rd(win(2, O_PND), v); check("R5 partial clear", v, 32'h2);
    wr(win(2, O_EN), 32'h0, 5'd0);
    check("R8 irq held", 32'(db_irq), 32'b0100);
    rd(win(2, O_PND), v); check("R8 pend held", v, 32'h2);
    wr(win(2, O_PND), 32'hFFFF_FFFF, 5'd0);
    check("R7 irq off", 32'(db_irq), 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(win(1, AW'(16)), v);  check("R11 gap", v, 0);
    rd(AW'(32'h100), v);     check("R11 low", v, 0);
    rd(win(4, O_EN), v);     check("R11 past end", v, 0);
  endtask

  initial begin
    #50000000;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable_rw();
    t_ring();
    t_clear_same_cycle();
    t_isolation();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule